// File: doc/BRIEF.md
# SECDED Memory Word Codec

This block guards a 64-bit memory word against bit flips with an extended Hamming code. Single flips are corrected and double flips are detected. On the write side, a 64-bit data word becomes a 72-bit codeword. Every codeword slot is addressed by its index:

- Check bits sit at the power-of-two indices.
- Slot 0 holds a parity bit that covers the whole word.
- Data fills every other slot, in ascending order.

On the read side, a 72-bit codeword becomes corrected data, a single-error flag, a double-error flag and the syndrome.

The syndrome is the XOR of the indices of all slots that read as one. The whole-word parity is then weighed against it:

- Parity odd and syndrome in range: one bit flipped, and that bit is inverted.
- Parity even and syndrome non-zero: two bits flipped. The word is passed through untouched and flagged, so the requester can repeat the access.

Each direction is a valid/ready channel with one output register. A word is accepted per cycle, and its result appears one cycle later.

Top module: `secded_codec`

## Requirements
- R1: Data bit j sits at the j-th non-zero, non-power-of-two codeword index in ascending order: data bit 0 at index 3, bit 1 at 5, bit 2 at 6, bit 3 at 7, bit 4 at 9, up to bit 63 at 71.
- R2: The check bit at index 2^k (k = 0..6) makes the count of ones even over every index that has bit k set.
- R3: Codeword bit 0 makes the count of ones in all 72 bits even.
- R4: A codeword without errors decodes to its original data with both flags low and syndrome 0.
- R5: A single flip at index p in 1..71 decodes to the original data, with the single flag high, the double flag low and syndrome p.
- R6: A flip of index 0 alone gives syndrome 0, the single flag high, the double flag low and unchanged data.
- R7: Two flips give the double flag high, the single flag low, a syndrome equal to the XOR of the two indices, and data taken from the received word with no bit inverted.
- R8: A syndrome above 71 with odd overall parity raises the double flag and leaves the data unmodified.
- R9: With output ready held high, a word accepted on one clock edge is presented on the next, and a new word may be accepted every cycle.
- R10: While output valid is high and output ready is low, valid stays high, the payload holds still and input ready is low.
- R11: Reset clears both output-valid signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| encInValid | input | 1 | Encoder input word offered |
| encInReady | output | 1 | Encoder can take a word |
| encData | input | 64 | Data word to encode |
| encOutValid | output | 1 | Codeword available |
| encOutReady | input | 1 | Consumer takes the codeword |
| encCode | output | 72 | Encoded codeword |
| decInValid | input | 1 | Decoder input word offered |
| decInReady | output | 1 | Decoder can take a word |
| decCode | input | 72 | Codeword read back from storage |
| decOutValid | output | 1 | Decoded result available |
| decOutReady | input | 1 | Consumer takes the result |
| decData | output | 64 | Corrected data |
| decSingle | output | 1 | One error seen and corrected |
| decDouble | output | 1 | Uncorrectable error; retry requested |
| decSyndrome | output | 7 | XOR of indices of set bits |

## Verification
Both the codeword and every decoder result are due exactly one rising edge after the edge that accepts the input. The bench drives stimulus at the falling edge and samples one nanosecond after the next rising edge, so each check reads the registered result in the cycle it first appears. The stall and back-to-back tests keep the same sampling point across several edges. These tests check that a held payload persists and that a replacement lands on the very edge where ready returns.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef struct packed {
    logic loadEnc;
    logic loadDec;
  } codec_strobe_t;

  function automatic bit isPow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Ordinal of a data slot among non-power-of-two indices >= 1.
  function automatic int dataIdx(int p);
    return p - 1 - $clog2(p + 1);
  endfunction

endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    inValid,
  output logic [1:0]    inReady,
  output logic [1:0]    outValid,
  input  logic [1:0]    outReady,
  output codec_strobe_t strobe
);
  // channel 0 = encoder, channel 1 = decoder
  logic [1:0] load;
  logic [1:0] validQ;

  for (genvar c = 0; c < 2; c++) begin : gChan
    assign inReady[c] = !validQ[c] || outReady[c];
    assign load[c]    = inValid[c] && inReady[c];

    always_ff @(posedge clk) begin
      if (rst)            validQ[c] <= 1'b0;
      else if (load[c])   validQ[c] <= 1'b1;
      else if (outReady[c]) validQ[c] <= 1'b0;
    end

    // R10: a stalled result keeps its valid
    a_r10_valid_held: assert property (@(posedge clk) disable iff (rst)
      validQ[c] && !outReady[c] |=> validQ[c]);

    // R9: a result only appears after an offered input
    a_r9_valid_from_input: assert property (@(posedge clk) disable iff (rst)
      $rose(validQ[c]) |-> $past(inValid[c]));
  end

  assign outValid       = validQ;
  assign strobe.loadEnc = load[0];
  assign strobe.loadDec = load[1];
endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PAR_W  = 7,
  parameter int CW_W   = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  codec_strobe_t     strobe,
  input  logic [DATA_W-1:0] encData,
  input  logic [CW_W-1:0]   decCode,
  output logic [CW_W-1:0]   encCodeQ,
  output logic [DATA_W-1:0] decDataQ,
  output logic              decSingleQ,
  output logic              decDoubleQ,
  output logic [PAR_W-1:0]  decSynQ
);

  function automatic logic [CW_W-1:0] coverMask(int k);
    logic [CW_W-1:0] m;
    m = '0;
    for (int i = 1; i < CW_W; i++)
      if (((i >> k) & 1) == 1) m[i] = 1'b1;
    return m;
  endfunction

  // ---------------- encoder ----------------
  logic [CW_W-1:0]  dataPlaced;
  logic [PAR_W-1:0] checkBits;
  logic [CW_W-1:0]  encWord;

  for (genvar p = 0; p < CW_W; p++) begin : gPlace
    if (p != 0 && !isPow2(p)) begin : gData
      assign dataPlaced[p] = encData[dataIdx(p)];
    end else begin : gHole
      assign dataPlaced[p] = 1'b0;
    end
  end

  for (genvar k = 0; k < PAR_W; k++) begin : gCheck
    assign checkBits[k] = ^(dataPlaced & coverMask(k));
  end

  always_comb begin
    encWord = dataPlaced;
    for (int k = 0; k < PAR_W; k++) encWord[1 << k] = checkBits[k];
    encWord[0] = ^encWord;
  end

  // ---------------- decoder ----------------
  logic [PAR_W-1:0]  syn;
  logic              parOdd, synNonZero, inRange, fixEn, isSingle, isDouble;
  logic [DATA_W-1:0] decDataNext;

  always_comb begin
    syn = '0;
    for (int i = 1; i < CW_W; i++)
      if (decCode[i]) syn = syn ^ PAR_W'(i);
  end

  assign parOdd     = ^decCode;
  assign synNonZero = |syn;
  assign inRange    = syn <= PAR_W'(CW_W - 1);
  assign fixEn      = parOdd && synNonZero && inRange;
  assign isSingle   = parOdd && (!synNonZero || inRange);
  assign isDouble   = synNonZero && (!parOdd || !inRange);

  for (genvar p = 1; p < CW_W; p++) begin : gExtract
    if (!isPow2(p)) begin : gData
      assign decDataNext[dataIdx(p)] = decCode[p] ^ (fixEn && (syn == PAR_W'(p)));
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      encCodeQ   <= '0;
      decDataQ   <= '0;
      decSingleQ <= 1'b0;
      decDoubleQ <= 1'b0;
      decSynQ    <= '0;
    end else begin
      if (strobe.loadEnc) encCodeQ <= encWord;
      if (strobe.loadDec) begin
        decDataQ   <= decDataNext;
        decSingleQ <= isSingle;
        decDoubleQ <= isDouble;
        decSynQ    <= syn;
      end
    end
  end

  // R10: payloads hold while nothing is loaded
  a_r10_enc_payload_stable: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadEnc |=> $stable(encCodeQ));
  a_r10_dec_payload_stable: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadDec |=> $stable(decDataQ) && $stable(decSynQ));
  // R7: an uncorrectable word always carries a non-zero syndrome
  a_r7_double_nonzero_syn: assert property (@(posedge clk) disable iff (rst)
    decDoubleQ |-> decSynQ != '0);
  // R5: the two flags never rise together
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(decSingleQ && decDoubleQ));
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PAR_W  = 7,
  localparam int CW_W  = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              encInValid,
  output logic              encInReady,
  input  logic [DATA_W-1:0] encData,
  output logic              encOutValid,
  input  logic              encOutReady,
  output logic [CW_W-1:0]   encCode,
  input  logic              decInValid,
  output logic              decInReady,
  input  logic [CW_W-1:0]   decCode,
  output logic              decOutValid,
  input  logic              decOutReady,
  output logic [DATA_W-1:0] decData,
  output logic              decSingle,
  output logic              decDouble,
  output logic [PAR_W-1:0]  decSyndrome
);
  codec_strobe_t strobe;
  logic [1:0] inReadyV, outValidV;

  secded_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  ({decInValid, encInValid}),
    .inReady  (inReadyV),
    .outValid (outValidV),
    .outReady ({decOutReady, encOutReady}),
    .strobe   (strobe)
  );

  secded_datapath #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CW_W(CW_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .encData    (encData),
    .decCode    (decCode),
    .encCodeQ   (encCode),
    .decDataQ   (decData),
    .decSingleQ (decSingle),
    .decDoubleQ (decDouble),
    .decSynQ    (decSyndrome)
  );

  assign encInReady  = inReadyV[0];
  assign decInReady  = inReadyV[1];
  assign encOutValid = outValidV[0];
  assign decOutValid = outValidV[1];

  // R11: nothing is valid in the cycle after reset
  a_r11_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> !encOutValid && !decOutValid);
endmodule

// File: tb/secded_codec_test.sv
`timescale 1ns/1ps
module secded_codec_test;
  logic clk = 0;
  logic rst = 1;
  logic encInValid = 0, encOutReady = 1, decInValid = 0, decOutReady = 1;
  logic [63:0] encData = '0;
  logic [71:0] decCode = '0;
  logic encInReady, encOutValid, decInReady, decOutValid, decSingle, decDouble;
  logic [71:0] encCode;
  logic [63:0] decData;
  logic [6:0]  decSyndrome;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  secded_codec uut (.*);

  localparam logic [79:0] VECS [9] = '{
    {64'h0000000000000000, 8'hFF, 8'hFF},
    {64'hFFFFFFFFFFFFFFFF, 8'd5,  8'hFF},
    {64'h0123456789ABCDEF, 8'd71, 8'hFF},
    {64'hDEADBEEFCAFEF00D, 8'd0,  8'hFF},
    {64'h8000000000000001, 8'd64, 8'hFF},
    {64'hA5A5A5A5A5A5A5A5, 8'd3,  8'd70},
    {64'h0000000000000001, 8'd0,  8'd9},
    {64'hFFFF0000FFFF0000, 8'd1,  8'd2},
    {64'h5555555555555555, 8'd3,  8'hFF}
  };

  function automatic bit pow2(int i); return (i & (i - 1)) == 0; endfunction

  function automatic logic [71:0] refEncode(logic [63:0] d);
    logic [71:0] w = '0; logic [6:0] s = '0; int j = 0;
    for (int i = 1; i < 72; i++) if (!pow2(i)) begin w[i] = d[j]; j++; end
    for (int i = 1; i < 72; i++) if (w[i]) s ^= 7'(i);
    for (int k = 0; k < 7; k++) w[1 << k] = s[k];
    w[0] = ^w;
    return w;
  endfunction

  function automatic logic [63:0] refExtract(logic [71:0] w);
    logic [63:0] d = '0; int j = 0;
    for (int i = 1; i < 72; i++) if (!pow2(i)) begin d[j] = w[i]; j++; end
    return d;
  endfunction

  function automatic logic [71:0] dataMask();
    logic [71:0] m = '0;
    for (int i = 1; i < 72; i++) if (!pow2(i)) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doEncode(input logic [63:0] d, output logic [71:0] cw);
    @(negedge clk); encData = d; encInValid = 1;
    @(posedge clk); #1; encInValid = 0;
    check(encOutValid, "R9 encoder valid after one edge", 72'(encOutValid), 72'd1);
    cw = encCode;
  endtask

  task automatic doDecode(input logic [71:0] cw);
    @(negedge clk); decCode = cw; decInValid = 1;
    @(posedge clk); #1; decInValid = 0;
    check(decOutValid, "R9 decoder valid after one edge", 72'(decOutValid), 72'd1);
  endtask

  initial begin : watchdog
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [71:0] cw, exp, bad, m;
    logic [63:0] d, expData;
    logic [7:0] fa, fb;
    int nf;
    m = dataMask();
    repeat (3) @(posedge clk);
    #1;
    check(!encOutValid && !decOutValid, "R11 valids low in reset", 72'({encOutValid, decOutValid}), 72'd0);
    @(negedge clk); rst = 0;

    // R1 single-bit placement
    doEncode(64'h1, cw);
    check(cw[3] && ((cw & m) == 72'h8), "R1 data bit 0 at index 3", cw & m, 72'h8);
    doEncode(64'h8000000000000000, cw);
    check((cw & m) == (72'h1 << 71), "R1 data bit 63 at index 71", cw & m, 72'h1 << 71);

    for (int v = 0; v < 9; v++) begin
      d = VECS[v][79:16]; fa = VECS[v][15:8]; fb = VECS[v][7:0];
      doEncode(d, cw);
      exp = refEncode(d);
      check((cw & m) == (exp & m), "R1 data placement", cw & m, exp & m);
      check((cw & ~m & ~72'h1) == (exp & ~m & ~72'h1), "R2 check bits", cw & ~m, exp & ~m);
      check(cw[0] == exp[0] && (^cw) == 1'b0, "R3 overall parity", 72'(cw[0]), 72'(exp[0]));
      bad = cw; nf = 0;
      if (fa != 8'hFF) begin bad[fa] = ~bad[fa]; nf++; end
      if (fb != 8'hFF) begin bad[fb] = ~bad[fb]; nf++; end
      doDecode(bad);
      if (nf == 0) begin
        check(decData == d && !decSingle && !decDouble && decSyndrome == 0, "R4 clean word",
              {decSingle, decDouble, decData[63:0], decSyndrome[5:0]}, {2'b00, d, 6'd0});
      end else if (nf == 1) begin
        check(decData == d, fa == 0 ? "R6 index 0 data" : "R5 corrected data", 72'(decData), 72'(d));
        check(decSingle && !decDouble, fa == 0 ? "R6 flags" : "R5 flags", 72'({decSingle, decDouble}), 72'b10);
        check(decSyndrome == fa[6:0], fa == 0 ? "R6 syndrome zero" : "R5 syndrome", 72'(decSyndrome), 72'(fa[6:0]));
      end else begin
        expData = refExtract(bad);
        check(decData == expData, "R7 data untouched", 72'(decData), 72'(expData));
        check(!decSingle && decDouble, "R7 flags", 72'({decSingle, decDouble}), 72'b01);
        check(decSyndrome == (fa[6:0] ^ fb[6:0]), "R7 syndrome", 72'(decSyndrome), 72'(fa[6:0] ^ fb[6:0]));
      end
    end

    // R8: flips at 0, 8, 64 -> syndrome 72, odd parity
    doEncode(64'hCAFEBABE12345678, cw);
    bad = cw ^ ((72'h1 << 64) | (72'h1 << 8) | 72'h1);
    doDecode(bad);
    check(decDouble && !decSingle, "R8 out-of-range flagged", 72'({decSingle, decDouble}), 72'b01);
    check(decData == 64'hCAFEBABE12345678, "R8 data unmodified", 72'(decData), 72'(64'hCAFEBABE12345678));
    check(decSyndrome == 7'd72, "R8 syndrome", 72'(decSyndrome), 72'd72);

    // R9: back-to-back decoder words
    @(negedge clk); decCode = refEncode(64'h11); decInValid = 1;
    @(posedge clk); #1;
    check(decOutValid && decData == 64'h11, "R9 first of pair", 72'(decData), 72'h11);
    decCode = refEncode(64'h22);
    @(posedge clk); #1; decInValid = 0;
    check(decOutValid && decData == 64'h22, "R9 second of pair", 72'(decData), 72'h22);
    @(posedge clk); #1;
    check(!decOutValid, "R9 drains", 72'(decOutValid), 72'd0);

    // R10: decoder stall
    @(negedge clk); decOutReady = 0; decCode = refEncode(64'hAAAA); decInValid = 1;
    @(posedge clk); #1;
    decCode = refEncode(64'hBBBB);
    check(!decInReady, "R10 input ready low while stalled", 72'(decInReady), 72'd0);
    repeat (2) begin
      @(posedge clk); #1;
      check(decOutValid && decData == 64'hAAAA, "R10 held payload", 72'(decData), 72'hAAAA);
    end
    @(negedge clk); decOutReady = 1;
    @(posedge clk); #1; decInValid = 0;
    check(decOutValid && decData == 64'hBBBB, "R10 replacement on release", 72'(decData), 72'hBBBB);
    @(posedge clk); #1;
    check(!decOutValid, "R10 drained", 72'(decOutValid), 72'd0);

    // R10: encoder stall
    @(negedge clk); encOutReady = 0; encData = 64'h77; encInValid = 1;
    @(posedge clk); #1; encInValid = 0;
    exp = refEncode(64'h77);
    repeat (2) begin
      @(posedge clk); #1;
      check(encOutValid && encCode == exp, "R10 encoder held", encCode, exp);
    end

    // R11: reset while a result is held
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check(!encOutValid && !decOutValid, "R11 reset clears valids", 72'({encOutValid, decOutValid}), 72'd0);
    @(negedge clk); rst = 0; encOutReady = 1;
    @(posedge clk); #1;
    check(encInReady && decInReady, "R11 ready after reset", 72'({encInReady, decInReady}), 72'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule